// File: doc/BRIEF.md
# Interrupt Mask Duration Profiler

This block sits beside a processor core and measures how long the core keeps its interrupts masked. It watches two mask bits: the ordinary maskable-interrupt mask and the separate mask that gates the non-maskable request line. At every instruction boundary strobe it samples both bits. For each bit it times the intervals during which the bit is held set, using one shared free-running cycle counter. Each of the two trackers keeps the shortest, the longest and the most recent completed interval. A third unit counts interrupt-taken events.

All statistics are presented as plain register-style outputs that a host can read at any moment. While a mask interval is still open, each tracker also shows the time elapsed so far. That running value is folded into the reported longest interval. Until the first interval of a tracker has closed, its reported shortest value simply mirrors its reported longest value.

Top module: `irq_mask_profiler`

## Requirements
- R1: After reset, every tracker shows no open interval, a last duration of 0, a reported longest of 0 and a reported shortest of 0, and the event count is 0.
- R2: On a clock edge where the strobe is high, the mask bit is 1 and no interval is open, the tracker opens an interval. Its start is the cycle counter value at that edge, where the counter is 0 at the first edge after reset and advances by one per clock. From the next cycle on, the elapsed output reads the clock edges since the opening edge: 1, then 2, and so on.
- R3: Mask bit changes on edges without the strobe have no effect: an interval neither opens nor closes, and the stored statistics stay as they were.
- R4: On a strobed edge with the mask bit 0 and an interval open, the interval closes. Its duration is the counter value at the closing edge minus the start, and that duration becomes the last value.
- R5: A closing duration replaces the stored shortest only when it is strictly smaller. The stored shortest resets to all ones.
- R6: A closing duration replaces the stored longest only when it is strictly larger. The stored longest resets to 0.
- R7: While the stored shortest is still all ones, the reported shortest equals the reported longest.
- R8: While an interval is open, the reported longest is the larger of the stored longest and the elapsed time.
- R9: The second tracker behaves in exactly the same way on the non-maskable mask bit. Neither tracker affects the outputs of the other.
- R10: The event count rises by exactly one on each edge where the taken input is high, and holds otherwise.
- R11: The elapsed output reads 0 whenever no interval is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_i | input | 1 | Instruction boundary strobe; mask bits are sampled only when high |
| imask_i | input | 1 | Maskable-interrupt mask bit of the core |
| xmask_i | input | 1 | Non-maskable-request mask bit of the core |
| take_i | input | 1 | One pulse per interrupt taken |
| i_open_o | output | 1 | Maskable tracker has an open interval |
| i_live_o | output | 32 | Elapsed cycles of the open maskable interval, else 0 |
| i_min_o | output | 32 | Reported shortest maskable interval |
| i_max_o | output | 32 | Reported longest maskable interval |
| i_last_o | output | 32 | Most recent completed maskable interval |
| x_open_o | output | 1 | Non-maskable tracker has an open interval |
| x_live_o | output | 32 | Elapsed cycles of the open non-maskable interval, else 0 |
| x_min_o | output | 32 | Reported shortest non-maskable interval |
| x_max_o | output | 32 | Reported longest non-maskable interval |
| x_last_o | output | 32 | Most recent completed non-maskable interval |
| take_cnt_o | output | 16 | Count of interrupts taken |

## Verification
Directed runs first close three intervals of lengths 5, 3 and 9. These show that the shortest value moves only on a smaller duration and the longest only on a larger one. An interval is then left open past the stored longest, which separates the live-inclusive longest from the stored one and shows the shortest fallback. Mask toggles without the strobe show that only strobed samples count, and an interval opened on one bit alone shows that the two trackers are independent. A long random run then mixes sparse strobes, slowly drifting masks and taken pulses. Every output is compared each cycle against a bench model that counts edges on its own.

// File: rtl/irq_prof_pkg.sv
`timescale 1ns/1ps
package irq_prof_pkg;
  typedef enum int unsigned {
    MASK_SEL_I = 0,
    MASK_SEL_X = 1
  } mask_sel_e;

  localparam int unsigned NUM_MASKS = 2;
endpackage

// File: rtl/cycle_counter.sv
`timescale 1ns/1ps
module cycle_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] now_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + W'(1);
  end

  assign now_o = cnt_q;
endmodule

// File: rtl/event_tally.sv
`timescale 1ns/1ps
module event_tally #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hit_i,
  output logic [W-1:0] count_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt_q <= '0;
    else if (hit_i) cnt_q <= cnt_q + W'(1);
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/mask_span_tracker.sv
`timescale 1ns/1ps
module mask_span_tracker #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_i,
  input  logic         mask_i,
  input  logic [W-1:0] now_i,
  output logic         open_o,
  output logic         open_ev_o,
  output logic         close_ev_o,
  output logic [W-1:0] live_o,
  output logic [W-1:0] min_o,
  output logic [W-1:0] max_o,
  output logic [W-1:0] last_o
);
  localparam logic [W-1:0] NONE_YET = '1;

  function automatic logic [W-1:0] span(input logic [W-1:0] now, input logic [W-1:0] start);
    return now - start;
  endfunction

  function automatic logic [W-1:0] larger(input logic [W-1:0] a, input logic [W-1:0] b);
    return (b > a) ? b : a;
  endfunction

  function automatic logic [W-1:0] smaller(input logic [W-1:0] a, input logic [W-1:0] b);
    return (b < a) ? b : a;
  endfunction

  logic         open_q;
  logic [W-1:0] start_q;
  logic [W-1:0] min_q;
  logic [W-1:0] max_q;
  logic [W-1:0] last_q;
  logic [W-1:0] dur_w;
  logic [W-1:0] rep_max_w;

  assign open_ev_o  = step_i &  mask_i & ~open_q;
  assign close_ev_o = step_i & ~mask_i &  open_q;
  assign dur_w      = span(now_i, start_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q  <= 1'b0;
      start_q <= '0;
      min_q   <= NONE_YET;
      max_q   <= '0;
      last_q  <= '0;
    end else if (open_ev_o) begin
      open_q  <= 1'b1;
      start_q <= now_i;
    end else if (close_ev_o) begin
      open_q  <= 1'b0;
      min_q   <= smaller(min_q, dur_w);
      max_q   <= larger(max_q, dur_w);
      last_q  <= dur_w;
    end
  end

  assign live_o    = open_q ? dur_w : '0;
  assign rep_max_w = larger(max_q, live_o);
  assign open_o    = open_q;
  assign max_o     = rep_max_w;
  assign min_o     = (min_q == NONE_YET) ? rep_max_w : min_q;
  assign last_o    = last_q;
endmodule

// File: rtl/irq_mask_profiler.sv
`timescale 1ns/1ps
module irq_mask_profiler #(
  parameter int unsigned CYC_W  = 32,
  parameter int unsigned TAKE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_i,
  input  logic              imask_i,
  input  logic              xmask_i,
  input  logic              take_i,
  output logic              i_open_o,
  output logic [CYC_W-1:0]  i_live_o,
  output logic [CYC_W-1:0]  i_min_o,
  output logic [CYC_W-1:0]  i_max_o,
  output logic [CYC_W-1:0]  i_last_o,
  output logic              x_open_o,
  output logic [CYC_W-1:0]  x_live_o,
  output logic [CYC_W-1:0]  x_min_o,
  output logic [CYC_W-1:0]  x_max_o,
  output logic [CYC_W-1:0]  x_last_o,
  output logic [TAKE_W-1:0] take_cnt_o
);
  import irq_prof_pkg::*;

  logic [CYC_W-1:0]     now_w;
  logic [NUM_MASKS-1:0] mask_vec;
  logic [NUM_MASKS-1:0] open_vec;
  logic [NUM_MASKS-1:0] open_ev_vec;
  logic [NUM_MASKS-1:0] close_ev_vec;
  logic [CYC_W-1:0]     live_a [NUM_MASKS];
  logic [CYC_W-1:0]     min_a  [NUM_MASKS];
  logic [CYC_W-1:0]     max_a  [NUM_MASKS];
  logic [CYC_W-1:0]     last_a [NUM_MASKS];

  assign mask_vec[MASK_SEL_I] = imask_i;
  assign mask_vec[MASK_SEL_X] = xmask_i;

  cycle_counter #(.W(CYC_W)) clock_i (
    .clk   (clk),
    .rst_n (rst_n),
    .now_o (now_w)
  );

  for (genvar g = 0; g < NUM_MASKS; g++) begin : g_trk
    mask_span_tracker #(.W(CYC_W)) trk_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .step_i     (step_i),
      .mask_i     (mask_vec[g]),
      .now_i      (now_w),
      .open_o     (open_vec[g]),
      .open_ev_o  (open_ev_vec[g]),
      .close_ev_o (close_ev_vec[g]),
      .live_o     (live_a[g]),
      .min_o      (min_a[g]),
      .max_o      (max_a[g]),
      .last_o     (last_a[g])
    );
  end

  event_tally #(.W(TAKE_W)) tally_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit_i   (take_i),
    .count_o (take_cnt_o)
  );

  assign i_open_o = open_vec[MASK_SEL_I];
  assign i_live_o = live_a[MASK_SEL_I];
  assign i_min_o  = min_a[MASK_SEL_I];
  assign i_max_o  = max_a[MASK_SEL_I];
  assign i_last_o = last_a[MASK_SEL_I];
  assign x_open_o = open_vec[MASK_SEL_X];
  assign x_live_o = live_a[MASK_SEL_X];
  assign x_min_o  = min_a[MASK_SEL_X];
  assign x_max_o  = max_a[MASK_SEL_X];
  assign x_last_o = last_a[MASK_SEL_X];
endmodule

// File: rtl/irq_prof_checker.sv
`timescale 1ns/1ps
module irq_prof_checker #(
  parameter int unsigned CYC_W  = 32,
  parameter int unsigned TAKE_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              step_i,
  input logic              imask_i,
  input logic              xmask_i,
  input logic              take_i,
  input logic [CYC_W-1:0]  now_w,
  input logic              i_open_o,
  input logic [CYC_W-1:0]  i_live_o,
  input logic [CYC_W-1:0]  i_min_o,
  input logic [CYC_W-1:0]  i_max_o,
  input logic [CYC_W-1:0]  i_last_o,
  input logic              x_open_o,
  input logic [CYC_W-1:0]  x_live_o,
  input logic [CYC_W-1:0]  x_last_o,
  input logic [TAKE_W-1:0] take_cnt_o
);
  assert_open_on_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(i_open_o) |-> $past(step_i && imask_i));

  assert_live_advances_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (i_open_o && $past(i_open_o)) |-> (i_live_o == $past(i_live_o) + CYC_W'(1)));

  assert_counter_runs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (now_w == $past(now_w) + CYC_W'(1)));

  assert_no_strobe_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && $past(rst_n)) |=> ($stable(i_open_o) && $stable(x_open_o)
                                   && $stable(i_last_o) && $stable(x_last_o)));

  assert_close_on_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(i_open_o) |-> $past(step_i && !imask_i));

  assert_last_is_elapsed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(i_open_o) |-> (i_last_o == $past(i_live_o)));

  assert_min_not_above_max_R5: assert property (@(posedge clk) disable iff (!rst_n)
    i_min_o <= i_max_o);

  assert_max_covers_live_R8: assert property (@(posedge clk) disable iff (!rst_n)
    i_open_o |-> (i_max_o >= i_live_o));

  assert_x_last_is_elapsed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(x_open_o) |-> (x_last_o == $past(x_live_o)));

  assert_x_open_on_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(x_open_o) |-> $past(step_i && xmask_i));

  assert_take_counts_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && take_i) |=> (take_cnt_o == $past(take_cnt_o) + TAKE_W'(1)));

  assert_take_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !take_i) |=> $stable(take_cnt_o));

  assert_live_zero_closed_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !i_open_o |-> (i_live_o == '0 ));
endmodule

bind irq_mask_profiler irq_prof_checker #(.CYC_W(CYC_W), .TAKE_W(TAKE_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .step_i     (step_i),
  .imask_i    (imask_i),
  .xmask_i    (xmask_i),
  .take_i     (take_i),
  .now_w      (now_w),
  .i_open_o   (i_open_o),
  .i_live_o   (i_live_o),
  .i_min_o    (i_min_o),
  .i_max_o    (i_max_o),
  .i_last_o   (i_last_o),
  .x_open_o   (x_open_o),
  .x_live_o   (x_live_o),
  .x_last_o   (x_last_o),
  .take_cnt_o (take_cnt_o)
);

// File: tb/irq_mask_profiler_tb_top.sv
`timescale 1ns/1ps
module irq_mask_profiler_tb_top;
  localparam int unsigned CW = 32;
  localparam int unsigned TW = 16;
  localparam logic [CW-1:0] ALL1 = '1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step_i = 1'b0, imask_i = 1'b0, xmask_i = 1'b0, take_i = 1'b0;
  logic          i_open_o, x_open_o;
  logic [CW-1:0] i_live_o, i_min_o, i_max_o, i_last_o;
  logic [CW-1:0] x_live_o, x_min_o, x_max_o, x_last_o;
  logic [TW-1:0] take_cnt_o;

  always #10 clk = ~clk;

  irq_mask_profiler #(.CYC_W(CW), .TAKE_W(TW)) dut_i (
    .clk(clk), .rst_n(rst_n), .step_i(step_i), .imask_i(imask_i),
    .xmask_i(xmask_i), .take_i(take_i),
    .i_open_o(i_open_o), .i_live_o(i_live_o), .i_min_o(i_min_o),
    .i_max_o(i_max_o), .i_last_o(i_last_o),
    .x_open_o(x_open_o), .x_live_o(x_live_o), .x_min_o(x_min_o),
    .x_max_o(x_max_o), .x_last_o(x_last_o), .take_cnt_o(take_cnt_o)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [CW-1:0] t_now;
  logic          m_open  [2];
  logic [CW-1:0] m_start [2];
  logic [CW-1:0] m_min   [2];
  logic [CW-1:0] m_max   [2];
  logic [CW-1:0] m_last  [2];
  logic [TW-1:0] m_take;

  task automatic chk(input string tag, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] exp_live(input int k);
    return m_open[k] ? (t_now - m_start[k]) : '0;
  endfunction

  function automatic logic [CW-1:0] exp_max(input int k);
    logic [CW-1:0] lv = exp_live(k);
    return (lv > m_max[k]) ? lv : m_max[k];
  endfunction

  function automatic logic [CW-1:0] exp_min(input int k);
    return (m_min[k] == ALL1) ? exp_max(k) : m_min[k];
  endfunction

  task automatic model_reset();
    t_now = '0;
    m_take = '0;
    for (int k = 0; k < 2; k++) begin
      m_open[k] = 1'b0; m_start[k] = '0; m_min[k] = ALL1; m_max[k] = '0; m_last[k] = '0;
    end
  endtask

  task automatic model_edge(input logic st, input logic mi, input logic mx, input logic tk);
    logic mk [2];
    logic [CW-1:0] d;
    mk[0] = mi; mk[1] = mx;
    for (int k = 0; k < 2; k++) begin
      if (st && mk[k] && !m_open[k]) begin
        m_open[k] = 1'b1; m_start[k] = t_now;
      end else if (st && !mk[k] && m_open[k]) begin
        d = t_now - m_start[k];
        m_open[k] = 1'b0;
        if (d < m_min[k]) m_min[k] = d;
        if (d > m_max[k]) m_max[k] = d;
        m_last[k] = d;
      end
    end
    if (tk) m_take = m_take + TW'(1);
    t_now = t_now + CW'(1);
  endtask

  task automatic compare_all();
    chk("R2 i_open", {31'd0, i_open_o}, {31'd0, m_open[0]});
    chk("R11 i_live", i_live_o, exp_live(0));
    chk("R5 i_min", i_min_o, exp_min(0));
    chk("R6 i_max", i_max_o, exp_max(0));
    chk("R4 i_last", i_last_o, m_last[0]);
    chk("R9 x_open", {31'd0, x_open_o}, {31'd0, m_open[1]});
    chk("R9 x_live", x_live_o, exp_live(1));
    chk("R9 x_min", x_min_o, exp_min(1));
    chk("R9 x_max", x_max_o, exp_max(1));
    chk("R9 x_last", x_last_o, m_last[1]);
    chk("R10 take", {16'd0, take_cnt_o}, {16'd0, m_take});
  endtask

  task automatic tick(input logic st, input logic mi, input logic mx, input logic tk);
    step_i = st; imask_i = mi; xmask_i = mx; take_i = tk;
    @(posedge clk);
    model_edge(st, mi, mx, tk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle(input int n, input logic mi, input logic mx);
    for (int j = 0; j < n; j++) tick(1'b0, mi, mx, 1'b0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic mi, mx;
    int seed;
    seed = $urandom(32'd2024);
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state, with R7 fallback
    chk("R1 reset last", i_last_o, '0);
    chk("R1 reset max", i_max_o, '0);
    chk("R7 reset min fallback", i_min_o, '0);
    chk("R1 reset take", {16'd0, take_cnt_o}, '0);
    idle(3, 1'b0, 1'b0);

    // R2/R4 interval of 5, then R5 and R6
    tick(1'b1, 1'b1, 1'b0, 1'b0);
    chk("R2 live after open", i_live_o, 32'd1);
    idle(4, 1'b1, 1'b0);
    chk("R8 max tracks live", i_max_o, 32'd5);
    chk("R7 min follows live max", i_min_o, 32'd5);
    tick(1'b1, 1'b0, 1'b0, 1'b0);
    chk("R4 first last", i_last_o, 32'd5);
    tick(1'b1, 1'b1, 1'b0, 1'b0);
    idle(2, 1'b1, 1'b0);
    tick(1'b1, 1'b0, 1'b0, 1'b0);
    chk("R5 min shrinks", i_min_o, 32'd3);
    chk("R6 max kept", i_max_o, 32'd5);
    tick(1'b1, 1'b1, 1'b0, 1'b0);
    idle(8, 1'b1, 1'b0);
    tick(1'b1, 1'b0, 1'b0, 1'b0);
    chk("R6 max grows", i_max_o, 32'd9);
    chk("R5 min kept", i_min_o, 32'd3);

    // R3 mask toggles without strobe
    idle(4, 1'b1, 1'b1);
    chk("R3 no open without strobe", {31'd0, i_open_o}, '0);
    tick(1'b1, 1'b1, 1'b0, 1'b0);
    idle(4, 1'b0, 1'b0);
    chk("R3 no close without strobe", {31'd0, i_open_o}, 32'd1);
    idle(8, 1'b0, 1'b0);
    chk("R8 live beyond stored max", i_max_o, 32'd13);
    tick(1'b1, 1'b0, 1'b0, 1'b0);
    chk("R11 live zero when closed", i_live_o, '0);

    // R9 independence
    tick(1'b1, 1'b0, 1'b1, 1'b0);
    idle(5, 1'b0, 1'b1);
    tick(1'b1, 1'b0, 1'b0, 1'b0);
    chk("R9 x last", x_last_o, 32'd6);
    chk("R9 i untouched", i_last_o, 32'd13);

    // R10 taken events
    for (int j = 0; j < 7; j++) tick(1'b0, 1'b0, 1'b0, 1'b1);
    chk("R10 seven takes", {16'd0, take_cnt_o}, 32'd7);

    // random phase
    mi = 1'b0; mx = 1'b0;
    for (int n = 0; n < 4000; n++) begin
      if (($urandom % 6) == 0) mi = ~mi;
      if (($urandom % 9) == 0) mx = ~mx;
      tick((($urandom % 3) == 0), mi, mx, (($urandom % 5) == 0));
    end
    finish_run();
  end
endmodule